// File: doc/BRIEF.md
# Address-Gated Serial Control Port

This block is a slave port on a three-wire synchronous serial link. The link has a serial clock, an enable line and a data line in, and one open-drain data line out. The whole port runs on the system clock. The serial inputs pass through two-flop synchronizers, and the port finds edges on the serial clock and enable by comparing successive synchronized samples.

A transaction has two phases. First, with enable low, the host clocks an 8-bit address into the port on rising serial-clock edges. When enable rises, the port decodes the last eight bits received. One code selects a 16-bit write to a control register. A second code selects a read, in which a parallel status word is shifted out. A third code selects a byte stream, which is handed on one byte at a time to a downstream CRC checker. Any other code makes the port ignore the rest of the transaction. The data phase runs while enable is high and ends when enable falls.

The output only ever pulls low or releases the line, so the port reports the line state as a single pull-low flag. The flag changes one system-clock cycle after the synchronized serial edge that causes the change.

Top module: `sctl_port`

## Requirements
- R1: While the synchronous active-low reset is asserted, and on the first cycle after it, the control register reads 0, the pull-low flag is 0 and the byte strobe is 0.
- R2: Address bits are taken on rising serial-clock edges while enable is low. The first bit is bit 0 of the address. Bits 0..7 equal to 0,1,0,1,1,1,1,1 (value 0xFA) select control write. Bits 1,1,0,1,1,1,1,1 (0xFB) select read. Bits 0,0,1,1,1,1,1,1 (0xFC) select byte input. At most one mode is active at a time.
- R3: In control write, data bits are taken on rising serial-clock edges, and the first bit becomes bit 0. The control register is updated only when enable falls after exactly 16 bits.
- R4: A control write with any bit count other than 16 (for example 15 or 17) leaves the control register unchanged.
- R5: In read, the status word is captured when enable rises. Its bit 0 is presented first, and each falling serial-clock edge moves on to the next bit. The pull-low flag is 1 when the presented bit is 0 and 0 when it is 1.
- R6: The pull-low flag is 0 whenever enable is low and during control-write and byte-input transactions.
- R7: In byte input, each group of 8 bits (first bit into bit 0) produces a strobe lasting exactly one cycle with the byte. This continues for as long as enable stays high. A partial group left when enable falls produces no strobe.
- R8: A transaction whose address matches none of the three codes changes nothing: no control update, no strobe and no pull-low.
- R9: A change of the status word after enable has risen does not alter the bits shifted out in that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host (asynchronous) |
| ser_en | input | 1 | Serial enable: low for address, high for data |
| ser_din | input | 1 | Serial data from host |
| ser_do_low | output | 1 | 1 = pull the open-drain data line low, 0 = release |
| status_word | input | 16 | Parallel word returned in read mode |
| ctrl_reg | output | 16 | Control register written in control-write mode |
| crc_byte | output | 8 | Byte handed to the CRC checker |
| crc_byte_vld | output | 1 | One-cycle strobe qualifying crc_byte |

## Verification
The hardest cases to reach are transactions that are almost correct. Examples are a control write that ends one bit short or one bit long, a byte stream that stops partway through a byte, and a valid-looking data phase that follows an unknown address. The bench drives these through the same bit-level tasks as the normal transfers, varying only the bit count or the address byte. It then observes the control register, the strobe queue and the pull-low flag, which must stay unchanged. Stability of the read data is tested by changing the status word in the middle of a read.

// File: rtl/sp_pkg.sv
// Shared types for the serial control port.
// Assumes: nothing beyond IEEE 1800-2017.
package sp_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_WR   = 2'd1,
        MODE_RD   = 2'd2,
        MODE_BYTE = 2'd3
    } sp_mode_e;
endpackage

// File: rtl/sp_sync.sv
// Two-flop synchronizer with one extra history stage and edge detection.
// Assumes: inputs are asynchronous and stay stable for several clk cycles.
module sp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] s_out,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, hist_q;

    // purpose: resynchronize the inputs and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= a_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign s_out = sync_q;
    assign rise  = sync_q & ~hist_q;
    assign fall  = ~sync_q & hist_q;
endmodule

// File: rtl/sp_addr.sv
// Address shift register, code decode and mode register.
// Assumes: strobes come from synchronized signals. The last AW bits before
// enable rises form the address, and the first bit lands in bit 0.
module sp_addr
    import sp_pkg::*;
#(
    parameter int          AW      = 8,
    parameter logic [AW-1:0] CODE_WR = 8'hFA,
    parameter logic [AW-1:0] CODE_RD = 8'hFB,
    parameter logic [AW-1:0] CODE_BY = 8'hFC
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_s,
    input  logic     en_rise,
    input  logic     en_fall,
    input  logic     sclk_rise,
    input  logic     din_s,
    output sp_mode_e mode,
    output logic     hit_rd
);
    logic [AW-1:0] addr_q;
    logic          hit_wr, hit_by;

    assign hit_wr = (addr_q == CODE_WR);
    assign hit_rd = (addr_q == CODE_RD);
    assign hit_by = (addr_q == CODE_BY);

    // purpose: collect address bits while enable is low, clear after each transaction
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (en_fall)
            addr_q <= '0;
        else if (sclk_rise && !en_s)
            addr_q <= {din_s, addr_q[AW-1:1]};
    end

    // purpose: choose the mode on enable rise, return to idle on enable fall
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_IDLE;
        else if (en_fall)
            mode <= MODE_IDLE;
        else if (en_rise) begin
            if (hit_wr)      mode <= MODE_WR;
            else if (hit_rd) mode <= MODE_RD;
            else if (hit_by) mode <= MODE_BYTE;
            else             mode <= MODE_IDLE;
        end
    end

    // R2: a mode is only entered on the cycle after an enable rise
    assert_mode_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_IDLE && mode != MODE_IDLE) |-> $past(en_rise));
    // R2: the mode is dropped when enable falls
    assert_mode_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> mode == MODE_IDLE);
endmodule

// File: rtl/sp_wr_path.sv
// Control-write data path: shift register, saturating bit counter, commit.
// Assumes: mode is held for the whole data phase. The first bit lands in bit 0.
module sp_wr_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          en_rise,
    input  logic          en_fall,
    input  logic          sclk_rise,
    input  logic          din_s,
    output logic [DW-1:0] ctrl_q
);
    localparam int CW = $clog2(DW + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(DW);
    localparam logic [CW-1:0] CNT_OVER = CW'(DW + 1);

    logic [DW-1:0] sh_q;
    logic [CW-1:0] cnt_q;

    // purpose: shift data bits in and count them, saturating past the word length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (en_rise) begin
            cnt_q <= '0;
        end else if (active && sclk_rise) begin
            sh_q <= {din_s, sh_q[DW-1:1]};
            if (cnt_q != CNT_OVER)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // purpose: commit the word only when enable falls after exactly DW bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (active && en_fall && cnt_q == CNT_FULL)
            ctrl_q <= sh_q;
    end

    // R3: the control register changes only on an enable fall during a write
    assert_ctrl_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> ($past(en_fall) && $past(active)));
    // R4: a write that ends on a bad count keeps the register
    assert_ctrl_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && cnt_q != CNT_FULL) |=> $stable(ctrl_q));
endmodule

// File: rtl/sp_byte_path.sv
// Byte-stream path: assembles BW-bit groups and strobes each one out.
// Assumes: the first bit of each group lands in bit 0. The strobe is one cycle.
module sp_byte_path #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          en_rise,
    input  logic          sclk_rise,
    input  logic          din_s,
    output logic [BW-1:0] byte_q,
    output logic          vld_q
);
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] CNT_LAST = CW'(BW - 1);

    logic [BW-1:0] sh_q;
    logic [CW-1:0] cnt_q;

    // purpose: shift bits in, and on every BW-th bit present the group with a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            byte_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (en_rise) begin
                cnt_q <= '0;
            end else if (active && sclk_rise) begin
                sh_q  <= {din_s, sh_q[BW-1:1]};
                cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    byte_q <= {din_s, sh_q[BW-1:1]};
                    vld_q  <= 1'b1;
                end
            end
        end
    end

    // R7: the strobe lasts one cycle
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);
    // R8: a strobe only follows a cycle spent in byte mode
    assert_strobe_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(active));
endmodule

// File: rtl/sp_rd_path.sv
// Read path: captures the status word on enable rise and shifts it out LSB first.
// Assumes: the host samples the line while the serial clock is high, and the
// word moves on to the next bit on each falling serial-clock edge.
module sp_rd_path #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          active,
    input  logic          sclk_fall,
    input  logic [SW-1:0] status,
    output logic          pull_low
);
    logic [SW-1:0] sh_q;

    // purpose: capture the status word and move it on one bit per falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= status;
        else if (active && sclk_fall)
            sh_q <= {1'b1, sh_q[SW-1:1]};
    end

    assign pull_low = active & ~sh_q[0];

    // R9: the shifted word changes only on a load or a falling serial-clock edge
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh_q) |-> ($past(load) || $past(sclk_fall)));
endmodule

// File: rtl/sctl_port.sv
// Address-gated serial control port: top level.
// Assumes: the serial clock and enable are much slower than clk (several
// cycles per level). The output is an open-drain pull-low flag.
module sctl_port
    import sp_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int SW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_en,
    input  logic          ser_din,
    output logic          ser_do_low,
    input  logic [SW-1:0] status_word,
    output logic [DW-1:0] ctrl_reg,
    output logic [BW-1:0] crc_byte,
    output logic          crc_byte_vld
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] s_vec, r_vec, f_vec;
    logic             sclk_rise, sclk_fall, en_s, en_rise, en_fall, din_s;
    logic             en_hist_q;
    sp_mode_e         mode;
    logic             hit_rd;

    sp_sync #(.W(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .a_in({ser_din, ser_en, ser_clk}),
        .s_out(s_vec), .rise(r_vec), .fall(f_vec)
    );

    assign sclk_rise = r_vec[0];
    assign sclk_fall = f_vec[0];
    assign en_s      = s_vec[1];
    assign en_rise   = r_vec[1];
    assign en_fall   = f_vec[1];
    assign din_s     = s_vec[2];

    sp_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .en_s(en_s), .en_rise(en_rise),
        .en_fall(en_fall), .sclk_rise(sclk_rise), .din_s(din_s),
        .mode(mode), .hit_rd(hit_rd)
    );

    sp_wr_path #(.DW(DW)) u_wr (
        .clk(clk), .rst_n(rst_n), .active(mode == MODE_WR),
        .en_rise(en_rise), .en_fall(en_fall), .sclk_rise(sclk_rise),
        .din_s(din_s), .ctrl_q(ctrl_reg)
    );

    sp_byte_path #(.BW(BW)) u_byte (
        .clk(clk), .rst_n(rst_n), .active(mode == MODE_BYTE),
        .en_rise(en_rise), .sclk_rise(sclk_rise), .din_s(din_s),
        .byte_q(crc_byte), .vld_q(crc_byte_vld)
    );

    sp_rd_path #(.SW(SW)) u_rd (
        .clk(clk), .rst_n(rst_n), .load(en_rise && hit_rd),
        .active(mode == MODE_RD), .sclk_fall(sclk_fall),
        .status(status_word), .pull_low(ser_do_low)
    );

    // purpose: previous synchronized enable, used only by the checks below
    always_ff @(posedge clk) begin
        if (!rst_n) en_hist_q <= 1'b0;
        else        en_hist_q <= en_s;
    end

    // R6: the line is released once enable has been low for a full cycle
    assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !en_hist_q) |-> !ser_do_low);
    // R1: the outputs are quiet on the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (ctrl_reg == '0 && !ser_do_low && !crc_byte_vld));
endmodule

// File: tb/tb_sctl_port.sv
`timescale 1ns/1ps
module tb_sctl_port;
    localparam int HALF = 40;   // serial half period in ns (10 system cycles)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
    logic        ser_do_low;
    logic [15:0] status_word = 16'h0000;
    logic [15:0] ctrl_reg;
    logic [7:0]  crc_byte;
    logic        crc_byte_vld;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    sctl_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_din(ser_din), .ser_do_low(ser_do_low), .status_word(status_word),
        .ctrl_reg(ctrl_reg), .crc_byte(crc_byte), .crc_byte_vld(crc_byte_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        ser_din = b;
        #HALF ser_clk = 1'b1;
        #HALF ser_clk = 1'b0;
    endtask

    task automatic addr_out(input logic [7:0] code);
        ser_en = 1'b0;
        for (int i = 0; i < 8; i++) bit_out(code[i]);
        #HALF ser_en = 1'b1;
        #HALF;
    endtask

    task automatic end_txn();
        #HALF ser_en = 1'b0;
        #(4 * HALF);
    endtask

    task automatic write_n(input logic [7:0] code, input logic [31:0] val, input int n);
        addr_out(code);
        for (int i = 0; i < n; i++) begin
            bit_out(val[i]);
            if (ser_do_low !== 1'b0) chk("R6 released during write", ser_do_low, 0);
        end
        end_txn();
    endtask

    // driver: pushes expected bytes into the scoreboard, then sends the bits
    task automatic bytes_out(input logic [7:0] b [], input int extra_bits);
        addr_out(8'hFC);
        foreach (b[k]) begin
            exp_q.push_back(b[k]);
            for (int i = 0; i < 8; i++) bit_out(b[k][i]);
        end
        for (int i = 0; i < extra_bits; i++) bit_out(1'b1);
        chk("R6 released in byte mode", ser_do_low, 0);
        end_txn();
    endtask

    task automatic read_chk(input logic [15:0] word, input logic [15:0] swap);
        status_word = word;
        addr_out(8'hFB);
        status_word = swap;    // R9: must not disturb the captured word
        for (int i = 0; i < 16; i++) begin
            chk($sformatf("R5 R9 read bit %0d", i), ser_do_low, !word[i]);
            #HALF ser_clk = 1'b1;
            #HALF ser_clk = 1'b0;
            #HALF;
        end
        end_txn();
        chk("R6 released after read", ser_do_low, 0);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && crc_byte_vld) begin
            if (exp_q.size() == 0) chk("R7 R8 unexpected strobe", crc_byte, 32'hFFFF);
            else chk("R7 byte value", crc_byte, exp_q.pop_front());
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk("R1 ctrl in reset", ctrl_reg, 0);
        chk("R1 line in reset", ser_do_low, 0);
        chk("R1 strobe in reset", crc_byte_vld, 0);
        rst_n = 1'b1;
        #(4 * HALF);

        write_n(8'hFA, 32'hA5C3, 16);
        chk("R2 R3 write A5C3", ctrl_reg, 16'hA5C3);
        write_n(8'hFA, 32'h1234, 16);
        chk("R3 write 1234", ctrl_reg, 16'h1234);
        write_n(8'hFA, 32'h7FFF, 15);
        chk("R4 15-bit write dropped", ctrl_reg, 16'h1234);
        write_n(8'hFA, 32'h1FFFF, 17);
        chk("R4 17-bit write dropped", ctrl_reg, 16'h1234);

        read_chk(16'h8E31, 16'h0000);
        read_chk(16'h0000, 16'hFFFF);

        bytes_out('{8'h3C, 8'hA1, 8'hFE}, 4);
        chk("R7 scoreboard drained", exp_q.size(), 0);
        bytes_out('{8'h00}, 0);
        chk("R7 single byte drained", exp_q.size(), 0);

        write_n(8'hFE, 32'hBEEF, 16);
        chk("R8 unknown code leaves ctrl", ctrl_reg, 16'h1234);
        write_n(8'hFD, 32'h00FF, 16);
        chk("R8 unknown code no pull", ser_do_low, 0);
        chk("R8 unknown code leaves ctrl again", ctrl_reg, 16'h1234);

        write_n(8'hFA, 32'h0001, 16);
        chk("R3 write 0001", ctrl_reg, 16'h0001);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule